// File: doc/BRIEF.md
# Power-Up Strap and Test-Clock Mode Controller

This block settles what a clock generator does in its first moments after power-on. While a power-on timer runs, the pin that later carries the reference clock acts as an input. Its level, together with a second strap pin, picks the processor/memory frequency pairing. When the timer expires the straps are frozen and that pin turns into a driven output. A second shared pin starts out as an active-low three-state control. It becomes an active-low power-down control once it is seen high, either when the timer expires or at any later time. A register bit can also hand the pin back to its three-state role.

From the three-state level and the first strap, the block derives one of three operating modes. In the high-impedance mode every clock output is floated. In the test mode each output group gets a fixed division of a test clock driven onto the reference input. In the normal mode a two-bit code is passed on to the frequency synthesiser, which lies outside this block. The test dividers share one phase counter, so the rising edges of every divided clock line up.

A three-state machine tracks the shared pin:
- STRAP: the timer is running and the straps are tracked.
- HOLD: the timer has expired but the pin was low at that moment, so it keeps its three-state role.
- RUN: the pin acts as power-down.

The transitions are:
- STRAP→RUN when the timer expires with the pin high.
- STRAP→HOLD when the timer expires with the pin low.
- HOLD→RUN on the first high level.

RUN is left only by reset.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While reset is asserted, every output is 0: mode_o=0 (high-impedance), freq_code_o=00, clk_oe_o, ref_pad_oe_o, pin_is_pd_o and grp_clk_o.
- R2: For WAIT_CYCLES clocks after reset, ref_pad_oe_o stays 0 and pin_is_pd_o stays 0. During this time the strap latch follows {ref_pad_in, fsel0_pin}, and freq_code_o shows that value two clocks after a pin change.
- R3: From the clock after timer expiry, ref_pad_oe_o is 1 until reset. The straps sampled at expiry are held, and later changes on ref_pad_in or fsel0_pin leave freq_code_o unchanged.
- R4: If the shared pin is high when the timer expires and pd_func_bit=1, pin_is_pd_o=1 and three-state control is off. A low level on share_pin_n then leaves mode_o at 2 (normal).
- R5: If the shared pin is low at expiry, pin_is_pd_o stays 0 and the pin keeps acting as three-state control. Once the pin goes high, pin_is_pd_o becomes 1.
- R6: With an effective three-state level of 0 and a latched fsel0 of 0, mode_o=0, clk_oe_o=0, grp_clk_o=0 and ref_clk_o=0.
- R7: With an effective three-state level of 0 and a latched fsel0 of 1, mode_o=1 (test). grp_clk_o bit 0 (cpu) and bit 1 (sdram) divide tclk by 4, bit 2 (66 MHz group) by 6, bit 3 (pci) and bit 4 (apic) by 12, and bit 5 (48 MHz group) by 2. Every divided output has a 50% duty cycle.
- R8: In the first cycle of test mode all six divided clocks are high together, and they rise together every 12 tclk cycles after that.
- R9: ref_clk_o follows tclk whenever ref_pad_oe_o=1 and the mode is not high-impedance. Otherwise it is 0.
- R10: In normal mode (mode_o=2), clk_oe_o=1, grp_clk_o=0 and freq_code_o={fsel1,fsel0}. The codes select cpu/sdram frequencies of 00: 66/100, 01: 100/100, 10: 133/133 and 11: 133/100.
- R11: pd_func_bit=0 makes the shared pin act as three-state control even in RUN, so pin_is_pd_o=0. pd_func_bit=1 restores the power-down role.
- R12: A change on share_pin_n reaches mode_o on the third rising tclk edge after it: two synchroniser stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Reference or overdriven test clock |
| rst_n | input | 1 | Active-low power-on reset |
| fsel0_pin | input | 1 | Strap pin for select bit 0 |
| ref_pad_in | input | 1 | Level on the reference pad while it is an input (select bit 1) |
| share_pin_n | input | 1 | Shared three-state / power-down pin, active low |
| pd_func_bit | input | 1 | Register bit: 1 gives the shared pin the power-down role, 0 the three-state role |
| mode_o | output | 2 | 0 high-impedance, 1 test, 2 normal |
| freq_code_o | output | 2 | Latched {fsel1,fsel0} code for the synthesiser |
| clk_oe_o | output | 1 | Clock output enable (0 floats every clock output) |
| ref_pad_oe_o | output | 1 | Reference pad direction, 1 is output |
| pin_is_pd_o | output | 1 | 1 when the shared pin acts as power-down |
| grp_clk_o | output | 6 | Test-mode group clocks: cpu, sdram, 66, pci, apic, 48 |
| ref_clk_o | output | 1 | Reference clock output |

## Verification
Timer expiry can arrive while the test dividers are already running. This happens when the shared pin is held low and fsel0 is high from reset. The divided clocks must keep their phase across the STRAP→HOLD step, while the reference pad flips direction in that same stretch. The bench provokes this by tracing the divided clocks every cycle over a window that spans expiry and comparing them against a phase model counted from the first test cycle. A second collision is a change of pd_func_bit that re-enters test mode from RUN. In that cycle the mode output and the restarted divider phase must both be correct, so every group must sample high on the very first test cycle.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2
    } pin_state_e;

    typedef enum logic [1:0] {
        MODE_HIZ  = 2'd0,
        MODE_TEST = 2'd1,
        MODE_NORM = 2'd2
    } clk_mode_e;

    localparam int NUM_GRP = 6;

    // divide ratio per group: cpu, sdram, 66, pci, apic, 48
    function automatic int grp_div(input int g);
        case (g)
            0:       return 4;
            1:       return 4;
            2:       return 6;
            3:       return 12;
            4:       return 12;
            default: return 2;
        endcase
    endfunction

    // least common multiple of all ratios: length of the shared phase cycle
    function automatic int cycle_len();
        int l;
        l = 1;
        for (int g = 0; g < NUM_GRP; g++) begin
            int a;
            int b;
            a = l;
            b = grp_div(g);
            while (b != 0) begin
                int t;
                t = a % b;
                a = b;
                b = t;
            end
            l = (l / a) * grp_div(g);
        end
        return l;
    endfunction

    localparam int TEST_CYC = cycle_len();

endpackage

// File: rtl/por_timer.sv
module por_timer #(
    parameter int unsigned WAIT_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(WAIT_CYCLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q[s] <= RST_VAL;
                    else        q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q[s] <= RST_VAL;
                    else        q[s] <= q[s-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/tck_divider.sv
module tck_divider
    import strap_mode_pkg::*;
#(
    parameter int N_OUT   = NUM_GRP,
    parameter int CYC_LEN = TEST_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [N_OUT-1:0] ph
);
    localparam int CW = $clog2(CYC_LEN);

    logic [CW-1:0] phase;

    // one phase counter for every group keeps all rising edges aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (!run)
            phase <= '0;
        else if (phase == CW'(CYC_LEN - 1))
            phase <= '0;
        else
            phase <= phase + CW'(1);
    end

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_grp
            localparam int D = grp_div(g);
            assign ph[g] = run && ((int'(phase) % D) < (D / 2));
        end
    endgenerate
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
    import strap_mode_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 28636,
    parameter int          SYNC_DEPTH  = 2
) (
    input  logic               tclk,
    input  logic               rst_n,
    input  logic               fsel0_pin,
    input  logic               ref_pad_in,
    input  logic               share_pin_n,
    input  logic               pd_func_bit,
    output logic [1:0]         mode_o,
    output logic [1:0]         freq_code_o,
    output logic               clk_oe_o,
    output logic               ref_pad_oe_o,
    output logic               pin_is_pd_o,
    output logic [NUM_GRP-1:0] grp_clk_o,
    output logic               ref_clk_o
);
    pin_state_e state_q, state_d;
    clk_mode_e  mode_q, mode_d;
    logic       tmr_done;
    logic       share_s;
    logic [1:0] fsel_q;
    logic [1:0] code_q;
    logic       oe_q, ref_oe_q, pd_q;
    logic       pd_fn, tri_eff_n;

    por_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_tmr (
        .clk     (tclk),
        .rst_n   (rst_n),
        .expired (tmr_done)
    );

    pin_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk   (tclk),
        .rst_n (rst_n),
        .din   (share_pin_n),
        .dout  (share_s)
    );

    tck_divider #(.N_OUT(NUM_GRP), .CYC_LEN(TEST_CYC)) u_div (
        .clk   (tclk),
        .rst_n (rst_n),
        .run   (mode_q == MODE_TEST),
        .ph    (grp_clk_o)
    );

    // state register
    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STRAP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STRAP: if (tmr_done) state_d = share_s ? ST_RUN : ST_HOLD;
            ST_HOLD:  if (share_s)  state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_STRAP;
        endcase
    end

    // strap latch: transparent during STRAP, frozen afterwards
    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n)
            fsel_q <= 2'b00;
        else if (state_q == ST_STRAP)
            fsel_q <= {ref_pad_in, fsel0_pin};
    end

    // mode decode
    always_comb begin
        pd_fn     = (state_q == ST_RUN) && pd_func_bit;
        tri_eff_n = pd_fn ? 1'b1 : share_s;
        if (tri_eff_n)
            mode_d = MODE_NORM;
        else if (fsel_q[0])
            mode_d = MODE_TEST;
        else
            mode_d = MODE_HIZ;
    end

    // registered outputs
    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_HIZ;
            code_q   <= 2'b00;
            oe_q     <= 1'b0;
            ref_oe_q <= 1'b0;
            pd_q     <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            code_q   <= fsel_q;
            oe_q     <= (mode_d != MODE_HIZ);
            ref_oe_q <= (state_q != ST_STRAP);
            pd_q     <= pd_fn;
        end
    end

    assign mode_o       = mode_q;
    assign freq_code_o  = code_q;
    assign clk_oe_o     = oe_q;
    assign ref_pad_oe_o = ref_oe_q;
    assign pin_is_pd_o  = pd_q;
    assign ref_clk_o    = tclk & ref_oe_q & (mode_q != MODE_HIZ);
endmodule

// File: rtl/strap_mode_chk.sv
module strap_mode_chk
    import strap_mode_pkg::*;
(
    input logic               tclk,
    input logic               rst_n,
    input logic [1:0]         mode_o,
    input logic [1:0]         freq_code_o,
    input logic               clk_oe_o,
    input logic               ref_pad_oe_o,
    input logic               pin_is_pd_o,
    input logic [NUM_GRP-1:0] grp_clk_o
);
    // R6
    hiz_quiet_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> (!clk_oe_o && grp_clk_o == '0));

    // R3
    refdir_keep_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        !$fell(ref_pad_oe_o));

    // R3
    code_frozen_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (ref_pad_oe_o && $past(ref_pad_oe_o)) |-> $stable(freq_code_o));

    // R4
    pd_no_tri_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        pin_is_pd_o |-> (mode_o == 2'd2));

    // R2
    strap_in_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        !ref_pad_oe_o |-> !pin_is_pd_o);

    // R10
    norm_quiet_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (clk_oe_o && grp_clk_o == '0));

    // R8
    edge_align_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        $rose(grp_clk_o[3]) |-> (grp_clk_o == '1));

    // R7
    half_toggle_chk: assert property (@(posedge tclk) disable iff (!rst_n)
        ((mode_o == 2'd1) && ($past(mode_o) == 2'd1)) |-> (grp_clk_o[5] != $past(grp_clk_o[5])));
endmodule

bind strap_mode_ctrl strap_mode_chk u_chk (
    .tclk         (tclk),
    .rst_n        (rst_n),
    .mode_o       (mode_o),
    .freq_code_o  (freq_code_o),
    .clk_oe_o     (clk_oe_o),
    .ref_pad_oe_o (ref_pad_oe_o),
    .pin_is_pd_o  (pin_is_pd_o),
    .grp_clk_o    (grp_clk_o)
);

// File: tb/strap_mode_ctrl_test.sv
module strap_mode_ctrl_test;
    localparam int WAITN = 40;

    logic tclk = 1'b0;
    logic rst_n = 1'b0;
    logic fsel0_pin = 1'b1, ref_pad_in = 1'b1, share_pin_n = 1'b1, pd_func_bit = 1'b1;
    logic [1:0] mode_o, freq_code_o;
    logic clk_oe_o, ref_pad_oe_o, pin_is_pd_o, ref_clk_o;
    logic [5:0] grp_clk_o;

    always #2 tclk = ~tclk;

    strap_mode_ctrl #(.WAIT_CYCLES(WAITN)) uut (
        .tclk(tclk), .rst_n(rst_n), .fsel0_pin(fsel0_pin), .ref_pad_in(ref_pad_in),
        .share_pin_n(share_pin_n), .pd_func_bit(pd_func_bit), .mode_o(mode_o),
        .freq_code_o(freq_code_o), .clk_oe_o(clk_oe_o), .ref_pad_oe_o(ref_pad_oe_o),
        .pin_is_pd_o(pin_is_pd_o), .grp_clk_o(grp_clk_o), .ref_clk_o(ref_clk_o)
    );

    typedef struct {
        string      rid;
        logic [12:0] ev;
        logic [12:0] msk;
    } exp_t;

    exp_t sbq[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    localparam logic [12:0] M_ALL   = 13'h1fff;
    localparam logic [12:0] M_NOGRP = 13'h1fc0;
    localparam logic [12:0] M_TEST  = 13'h193f; // skip code and pad direction

    wire [12:0] obs = {mode_o, freq_code_o, clk_oe_o, ref_pad_oe_o, pin_is_pd_o, grp_clk_o};

    function automatic logic [12:0] pk(input logic [1:0] m, input logic [1:0] c,
                                       input logic oe, input logic roe, input logic pd,
                                       input logic [5:0] g);
        return {m, c, oe, roe, pd, g};
    endfunction

    // expected test-mode pattern k cycles after entry (ratios from R7)
    function automatic logic [5:0] grp_at(input int k);
        int dv [6] = '{4, 4, 6, 12, 12, 2};
        logic [5:0] r;
        for (int g = 0; g < 6; g++) r[g] = ((k % dv[g]) < (dv[g] / 2));
        return r;
    endfunction

    task automatic cmp(input string rid, input logic [12:0] act, input logic [12:0] ev,
                       input logic [12:0] msk);
        n_cmp++;
        if ((act & msk) !== (ev & msk)) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (mask %h)", rid, act, ev, msk);
        end
    endtask

    task automatic expect_next(input string rid, input logic [12:0] ev, input logic [12:0] msk);
        exp_t e;
        @(posedge tclk);
        #1;
        e.rid = rid; e.ev = ev; e.msk = msk;
        sbq.push_back(e);
    endtask

    // monitor: compares queued expectations on falling edges
    initial begin
        forever begin
            @(negedge tclk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                cmp(e.rid, obs, e.ev, e.msk);
            end
        end
    end

    task automatic wait_test(input string rid);
        bit seen;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge tclk);
            if (mode_o == 2'd1) begin seen = 1; break; end
        end
        if (!seen) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: actual mode %0d expected 1", rid, mode_o);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // ---- power-on 1: shared pin high, straps 11 then 10
        expect_next("R1", pk(2'd0, 2'd0, 0, 0, 0, 6'h0), M_ALL);
        @(negedge tclk) rst_n = 1'b1;
        repeat (6) @(posedge tclk);
        expect_next("R2", pk(2'd2, 2'd3, 1, 0, 0, 6'h0), M_ALL);
        @(negedge tclk) ref_pad_in = 1'b0;
        repeat (3) @(posedge tclk);
        expect_next("R2", pk(2'd2, 2'd1, 1, 0, 0, 6'h0), M_ALL);
        @(posedge tclk); #1;
        n_cmp++; if (ref_clk_o !== 1'b0) begin n_bad++; $display("FAIL R9: actual %b expected 0", ref_clk_o); end
        @(negedge tclk) begin ref_pad_in = 1'b1; fsel0_pin = 1'b0; end
        repeat (50) @(posedge tclk);
        expect_next("R3", pk(2'd2, 2'd2, 1, 1, 1, 6'h0), M_ALL);
        expect_next("R10", pk(2'd2, 2'd2, 1, 1, 1, 6'h0), M_ALL);
        @(negedge tclk) begin fsel0_pin = 1'b1; ref_pad_in = 1'b0; share_pin_n = 1'b0; end
        repeat (5) @(posedge tclk);
        expect_next("R3", pk(2'd2, 2'd2, 1, 1, 1, 6'h0), M_ALL);
        expect_next("R4", pk(2'd2, 2'd2, 1, 1, 1, 6'h0), M_ALL);
        @(negedge tclk) pd_func_bit = 1'b0;
        repeat (4) @(posedge tclk);
        expect_next("R11", pk(2'd0, 2'd2, 0, 1, 0, 6'h0), M_ALL);
        expect_next("R6", pk(2'd0, 2'd2, 0, 1, 0, 6'h0), M_ALL);
        @(posedge tclk); #1;
        n_cmp++; if (ref_clk_o !== 1'b0) begin n_bad++; $display("FAIL R6: actual %b expected 0", ref_clk_o); end
        @(negedge tclk) share_pin_n = 1'b1;
        repeat (5) @(posedge tclk);
        expect_next("R11", pk(2'd2, 2'd2, 1, 1, 0, 6'h0), M_ALL);
        // R12 latency: unchanged after two edges, changed after the third
        @(negedge tclk) share_pin_n = 1'b0;
        repeat (2) @(posedge tclk);
        @(negedge tclk) cmp("R12", {11'h0, mode_o}, 13'd2, 13'h3);
        @(posedge tclk);
        @(negedge tclk) cmp("R12", {11'h0, mode_o}, 13'd0, 13'h3);
        @(negedge tclk) pd_func_bit = 1'b1;
        repeat (4) @(posedge tclk);
        expect_next("R11", pk(2'd2, 2'd2, 1, 1, 1, 6'h0), M_ALL);

        // ---- power-on 2: shared pin low, straps 01 -> test mode
        @(negedge tclk) begin rst_n = 1'b0; fsel0_pin = 1'b1; ref_pad_in = 1'b0; end
        repeat (3) @(posedge tclk);
        @(negedge tclk) rst_n = 1'b1;
        wait_test("R8");
        cmp("R8", {7'h0, grp_clk_o}, 13'h3f, 13'h3f);
        for (int k = 1; k < 60; k++)
            expect_next("R7", pk(2'd1, 2'd0, 1, 0, 0, grp_at(k)), M_TEST);
        repeat (5) @(posedge tclk);
        expect_next("R5", pk(2'd1, 2'd1, 1, 1, 0, 6'h0), M_NOGRP);
        @(posedge tclk); #1;
        n_cmp++; if (ref_clk_o !== 1'b1) begin n_bad++; $display("FAIL R9: actual %b expected 1", ref_clk_o); end
        @(negedge tclk); #1;
        n_cmp++; if (ref_clk_o !== 1'b0) begin n_bad++; $display("FAIL R9: actual %b expected 0", ref_clk_o); end
        @(negedge tclk) share_pin_n = 1'b1;
        repeat (5) @(posedge tclk);
        expect_next("R5", pk(2'd2, 2'd1, 1, 1, 1, 6'h0), M_ALL);
        @(negedge tclk) share_pin_n = 1'b0;
        repeat (5) @(posedge tclk);
        expect_next("R4", pk(2'd2, 2'd1, 1, 1, 1, 6'h0), M_ALL);
        @(negedge tclk) pd_func_bit = 1'b0;
        wait_test("R8");
        cmp("R8", {7'h0, grp_clk_o}, 13'h3f, 13'h3f);
        for (int k = 1; k < 13; k++)
            expect_next("R8", pk(2'd1, 2'd1, 1, 1, 0, grp_at(k)), M_ALL);

        // ---- power-on 3: straps 00, shared pin low -> high-impedance
        @(negedge tclk) begin rst_n = 1'b0; fsel0_pin = 1'b0; ref_pad_in = 1'b0; pd_func_bit = 1'b1; end
        repeat (3) @(posedge tclk);
        @(negedge tclk) rst_n = 1'b1;
        repeat (8) @(posedge tclk);
        expect_next("R6", pk(2'd0, 2'd0, 0, 0, 0, 6'h0), M_ALL);
        @(negedge tclk) share_pin_n = 1'b1;
        repeat (5) @(posedge tclk);
        expect_next("R10", pk(2'd2, 2'd0, 1, 0, 0, 6'h0), M_ALL);
        repeat (4) @(posedge tclk);
        summary();
        $finish;
    end
endmodule